// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Bank

This block is a full-duplex SPI master that a processor controls through three halfword registers: data, control and status. Writing a byte to the data register starts one 8-bit exchange. The byte goes out on MOSI, most significant bit first, while eight bits are gathered from MISO. Reading the data register returns the gathered byte. To receive without sending anything meaningful, software writes zero.

The control register holds an enable bit, two bits that select the clock mode, and a 7-bit divisor that sets the serial clock rate. One bit sets the idle level of SCK. The other picks whether data is sampled on the leading edge or on the trailing edge. Together they cover the four usual SPI modes. SCK runs from the system clock with a half-period of (divisor + 1) cycles. The status register shows whether a byte is being shifted and whether a received byte is waiting to be read. Chip select is not part of this block; a general-purpose output drives it.

Top module: `spi_host_regbank`

## Requirements
- R1: The control register sits at offset 2, with enable in bit 0, sample-mode (CPHA) in bit 7, idle level (CPOL) in bit 8 and the divisor in bits 15:9. It reads back as written, and all other bits read as zero.
- R2: A write to offset 0 starts an exchange of the low byte only when enable is set and no exchange is running. A write while busy or while disabled is ignored.
- R3: After an accepted start, SCK makes 16 edges. The first edge comes (divisor + 1) cycles after the write edge, and each later edge comes (divisor + 1) cycles after the one before it.
- R4: Whenever no exchange is running, SCK rests at the level held in control bit 8.
- R5: Status bit 0 (busy) at offset 4 is high from the cycle after an accepted write, for 16 × (divisor + 1) cycles.
- R6: MOSI carries the byte MSB first. With CPHA = 0 the first bit is valid from the start and the next bit appears on each trailing edge. With CPHA = 1 the next bit appears on each leading edge after the first. MOSI is low when idle.
- R7: MISO is sampled on leading edges when CPHA = 0 and on trailing edges when CPHA = 1. The eight sampled bits, first sample in bit 7, read back in bits 7:0 at offset 0, with bits 15:8 zero.
- R8: Status bit 1 (receive full) is set on the same cycle that busy falls at the end of an exchange. It is cleared by a read of offset 0.
- R9: Clearing enable during an exchange ends it. One cycle after the control write edge, busy is low, SCK is at its idle level and MOSI is low. The receive-full flag and the received byte are left unchanged.
- R10: Offsets other than 0, 2 and 4 read as zero. Writes to the status offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Byte offset of the register accessed |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; at offset 0 it clears receive full |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
Busy, MOSI and the first SCK level all update on the first clock edge after the write that started the exchange. SCK edge n shows up n × (divisor + 1) edges after that write. Busy falls and receive full rises together on edge 16 × (divisor + 1). An abort takes effect one edge after the control write. The bench advances a behavioural model by exactly one clock per stimulus and compares every output at the following falling edge. The slave is modelled from the same edge count, so MISO holds steady across each edge where it is sampled. Register reads are compared combinationally before the edge that applies the read strobe.

// File: rtl/spi_host_pkg.sv
// Shared constants and types for the SPI master.
// Assumes a halfword-wide register bank addressed by byte offset.
package spi_host_pkg;
    localparam int DIV_W    = 7;
    localparam int REG_W    = 16;
    localparam int OFS_DATA = 0;
    localparam int OFS_CTRL = 2;
    localparam int OFS_STAT = 4;

    // Control register image, MSB first, matching bit positions 15:0.
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             cpol;
        logic             cpha;
        logic [5:0]       rsvd;
        logic             en;
    } ctrl_t;
endpackage

// File: rtl/spi_host_regs.sv
// Register bank: control storage, start decode, read mux and read-clear strobe.
// Assumes single-cycle write/read strobes; read data is combinational.
module spi_host_regs
    import spi_host_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              busy,
    input  logic              rbf,
    input  logic [DATA_W-1:0] rx_byte,
    output logic [REG_W-1:0]  reg_rdata,
    output ctrl_t             ctrl,
    output logic              start,
    output logic              rd_clr
);
    localparam logic [REG_W-1:0] CTRL_MASK = 16'hFF81;

    logic hit_data, hit_ctrl, hit_stat;
    ctrl_t ctrl_q;

    // Offset decode.
    always_comb begin
        hit_data = (reg_addr == ADDR_W'(OFS_DATA));
        hit_ctrl = (reg_addr == ADDR_W'(OFS_CTRL));
        hit_stat = (reg_addr == ADDR_W'(OFS_STAT));
    end

    // Control register storage, reserved bits forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (reg_wr && hit_ctrl)
            ctrl_q <= ctrl_t'(reg_wdata & CTRL_MASK);
    end

    // Start and read-clear strobes for the shift engine.
    always_comb begin
        start  = reg_wr && hit_data && ctrl_q.en && !busy;
        rd_clr = reg_rd && hit_data;
    end

    // Read data mux.
    always_comb begin
        reg_rdata = '0;
        if (hit_data)
            reg_rdata = REG_W'(rx_byte);
        else if (hit_ctrl)
            reg_rdata = ctrl_q;
        else if (hit_stat)
            reg_rdata = {{(REG_W-2){1'b0}}, rbf, busy};
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/spi_host_clkgen.sv
// SCK pacing: emits a one-cycle tick every (div + 1) cycles while run is high.
// Assumes div is held steady during a transfer.
module spi_host_clkgen #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    // Half-period counter, parked at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt_q <= '0;
        else if (cnt_q == div)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == div);
endmodule

// File: rtl/spi_host_shifter.sv
// Shift engine: sequences 2*DATA_W SCK edges, shifts MOSI MSB first, samples
// MISO on the edge chosen by cpha, and keeps the receive buffer and its flag.
// Assumes start is only asserted while idle and enabled.
module spi_host_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cpha,
    input  logic              cpol,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tick,
    input  logic              miso,
    input  logic              rd_clr,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    output logic              rbf,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int EDGES = 2 * DATA_W;
    localparam int EW    = $clog2(EDGES);

    logic              busy_q, phase_q, rbf_q;
    logic [EW-1:0]     ecnt_q;
    logic [DATA_W-1:0] txsh_q, rxsh_q, rxbuf_q;
    logic              sample_now, last_edge, done;
    logic [DATA_W-1:0] rx_next;

    // Edge classification for the current tick.
    always_comb begin
        sample_now = (~ecnt_q[0]) ^ cpha;
        last_edge  = (ecnt_q == EW'(EDGES - 1));
        rx_next    = {rxsh_q[DATA_W-2:0], miso};
        done       = en && busy_q && tick && last_edge;
    end

    // Transfer sequencing, shifting and sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            ecnt_q  <= '0;
            txsh_q  <= '0;
            rxsh_q  <= '0;
        end else if (!en) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            ecnt_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q  <= 1'b1;
                phase_q <= 1'b0;
                ecnt_q  <= '0;
                txsh_q  <= tx_byte;
                rxsh_q  <= '0;
            end
        end else if (tick) begin
            phase_q <= ~phase_q;
            ecnt_q  <= ecnt_q + 1'b1;
            if (sample_now)
                rxsh_q <= rx_next;
            else if (ecnt_q != '0)
                txsh_q <= txsh_q << 1;
            if (last_edge) begin
                busy_q <= 1'b0;
                ecnt_q <= '0;
            end
        end
    end

    // Receive buffer and full flag; completion wins over a same-cycle read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbf_q   <= 1'b0;
            rxbuf_q <= '0;
        end else if (done) begin
            rbf_q   <= 1'b1;
            rxbuf_q <= sample_now ? rx_next : rxsh_q;
        end else if (rd_clr) begin
            rbf_q   <= 1'b0;
        end
    end

    assign busy    = busy_q;
    assign sck     = cpol ^ phase_q;
    assign mosi    = busy_q & txsh_q[DATA_W-1];
    assign rbf     = rbf_q;
    assign rx_byte = rxbuf_q;
endmodule

// File: rtl/spi_host_regbank.sv
// Top: register-mapped byte-wide SPI master. Wires the register bank, the
// SCK pacing counter and the shift engine. Chip select is handled elsewhere.
module spi_host_regbank
    import spi_host_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              sck_o,
    output logic              mosi_o,
    input  logic              miso_i
);
    ctrl_t             ctrl;
    logic              start, rd_clr, tick;
    logic              busy, rbf;
    logic              ctrl_en, ctrl_cpol;
    logic [DATA_W-1:0] rx_byte;

    assign ctrl_en   = ctrl.en;
    assign ctrl_cpol = ctrl.cpol;

    spi_host_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .busy(busy), .rbf(rbf),
        .rx_byte(rx_byte), .reg_rdata(reg_rdata), .ctrl(ctrl),
        .start(start), .rd_clr(rd_clr)
    );

    spi_host_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(busy && ctrl.en), .div(ctrl.div),
        .tick(tick)
    );

    spi_host_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .en(ctrl.en), .cpha(ctrl.cpha),
        .cpol(ctrl.cpol), .start(start), .tx_byte(reg_wdata[DATA_W-1:0]),
        .tick(tick), .miso(miso_i), .rd_clr(rd_clr), .busy(busy),
        .sck(sck_o), .mosi(mosi_o), .rbf(rbf), .rx_byte(rx_byte)
    );
endmodule

// File: rtl/spi_host_sva.sv
// Checker for the SPI master, bound to the top; relates bus, control and pins.
module spi_host_sva #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              en,
    input logic              cpol,
    input logic              busy,
    input logic              rbf,
    input logic              sck,
    input logic              mosi
);
    // R4: SCK rests at the idle level when no exchange runs.
    a_r4_sck_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck == cpol);
    // R9: a clear enable leaves no exchange running on the next cycle.
    a_r9_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy);
    // R2: an exchange only begins after an enabled data write.
    a_r2_start_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr && reg_addr == ADDR_W'(0) && en));
    // R8: receive full rises only as busy falls.
    a_r8_flag_with_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rbf) |-> $fell(busy));
    // R6: MOSI is quiet when idle.
    a_r6_mosi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mosi);
endmodule

bind spi_host_regbank spi_host_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .en(ctrl_en), .cpol(ctrl_cpol), .busy(busy), .rbf(rbf),
    .sck(sck_o), .mosi(mosi_o)
);

// File: tb/spi_host_regbank_tb.sv
module spi_host_regbank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        sck_o, mosi_o;
    logic        miso_i = 1'b0;

    int checks = 0, errors = 0;
    bit finished = 0;

    // Behavioural reference state.
    bit       m_en, m_cpha, m_cpol, m_active, m_rbf;
    int       m_div, m_t;
    bit [7:0] m_tx, m_rxbuf, slave_b;

    always #2.5 clk = ~clk;

    spi_host_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i)
    );

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h t=%0t", req, got, exp, $time);
        end
    endtask

    function automatic int edges_done();
        return m_active ? m_t / (m_div + 1) : 0;
    endfunction

    function automatic int bit_idx();
        int e = edges_done();
        if (!m_cpha) return 7 - e / 2;
        return (e == 0) ? 7 : 7 - (e - 1) / 2;
    endfunction

    function automatic int exp_read(bit [2:0] a);
        case (a)
            3'd0: return {8'h0, m_rxbuf};
            3'd2: return {m_div[6:0], m_cpol, m_cpha, 6'b0, m_en};
            3'd4: return {14'b0, m_rbf, m_active};
            default: return 0;
        endcase
    endfunction

    // Advance one clock with the given bus inputs and compare every output.
    task automatic step(bit wr, bit rd, bit [2:0] a, bit [15:0] wd);
        bit ok_start, done;
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        #1;
        if (rd) chk(a == 0 ? "R7 rdata" : (a == 2 ? "R1 rdata" :
                    (a == 4 ? "R5/R8 rdata" : "R10 rdata")), reg_rdata, exp_read(a));
        @(posedge clk);
        @(negedge clk);
        ok_start = wr && a == 0 && m_en && !m_active;
        done = 0;
        if (!m_en) m_active = 0;
        else if (!m_active) begin
            if (ok_start) begin m_active = 1; m_t = 0; m_tx = wd[7:0]; end
        end else begin
            m_t++;
            if (m_t == 16 * (m_div + 1)) begin done = 1; m_active = 0; end
        end
        if (done) begin m_rbf = 1; m_rxbuf = slave_b; end
        else if (rd && a == 0) m_rbf = 0;
        if (wr && a == 2) begin
            m_en = wd[0]; m_cpha = wd[7]; m_cpol = wd[8]; m_div = int'(wd[15:9]);
        end
        miso_i = m_active ? slave_b[bit_idx()] : 1'b0;
        chk("R5 busy", dut_i.busy, m_active);
        chk("R3/R4 sck", sck_o, m_cpol ^ edges_done()[0]);
        chk("R6 mosi", mosi_o, m_active ? m_tx[bit_idx()] : 0);
        chk("R8 rbf", dut_i.rbf, m_rbf);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0);
    endtask

    task automatic config_ctrl(int div, bit cpol, bit cpha, bit en);
        step(1, 0, 2, {div[6:0], cpol, cpha, 6'b0, en});
    endtask

    task automatic exchange(bit [7:0] tx, bit [7:0] sl);
        slave_b = sl;
        step(1, 0, 0, {8'h0, tx});
        while (m_active) step(0, 0, 0, 0);
        idle(2);
        step(0, 1, 4, 0);   // R8 flag set
        step(0, 1, 0, 0);   // R7 byte, clears R8 flag
        step(0, 1, 4, 0);   // R8 flag cleared
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state (R4, R5, R6, R1)
        #1;
        chk("R4 reset sck", sck_o, 0);
        chk("R6 reset mosi", mosi_o, 0);
        step(0, 1, 4, 0);
        step(0, 1, 2, 0);
        // R1: reserved bits read zero
        step(1, 0, 2, 16'hFFFF);
        step(0, 1, 2, 0);
        config_ctrl(0, 0, 0, 0);
        // R2: write while disabled ignored
        step(1, 0, 0, 16'h00AA);
        idle(4);
        // Modes 0..3 with several divisors (R3, R6, R7)
        config_ctrl(0, 0, 0, 1); exchange(8'hA5, 8'h3C);
        config_ctrl(2, 0, 1, 1); exchange(8'h5A, 8'hC3);
        config_ctrl(1, 1, 0, 1); exchange(8'h81, 8'h7E);
        config_ctrl(3, 1, 1, 1); exchange(8'hF0, 8'h0F);
        // R2: write while busy ignored
        config_ctrl(1, 0, 0, 1);
        slave_b = 8'h96;
        step(1, 0, 0, 16'h00C7);
        idle(5);
        step(1, 0, 0, 16'h0011);
        while (m_active) step(0, 0, 0, 0);
        step(0, 1, 0, 0);
        // R9: abort mid-transfer keeps flag and byte
        step(0, 1, 0, 0);
        config_ctrl(1, 1, 0, 1);
        slave_b = 8'h55;
        step(1, 0, 0, 16'h00E1);
        idle(10);
        config_ctrl(1, 1, 0, 0);
        idle(3);
        step(0, 1, 4, 0);
        step(0, 1, 0, 0);
        // R10: unmapped read, status write ignored
        step(0, 1, 6, 0);
        step(1, 0, 4, 16'hFFFF);
        step(0, 1, 4, 0);
        // R3: maximum divisor
        config_ctrl(127, 0, 1, 1); exchange(8'h3D, 8'hB2);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule